// File: doc/BRIEF.md
# Masked Event Interrupt Fan-out

This unit collects status events for a network controller and turns them into individual interrupt request lines. It keeps a 32-bit event register and a 32-bit mask register. Pulses from elsewhere in the controller set event bits. Software clears event bits by writing ones to the event register. Thirteen of the event bits each drive one interrupt line through the mask. Each line is high exactly while its event bit and its mask bit are both set.

Two register writes raise events as a side effect. A write to the management frame register raises the management-done event. A write to the transmit control register with bit 0 set raises the graceful-stop event at once. Reads of the event and mask registers are combinational. Register updates take effect at the clock edge of the write or pulse. Each interrupt line follows the registered state with no further delay.

Top module: `evirq_unit`

## Requirements
- R1: After the asynchronous reset, the event register, the mask register and all 13 interrupt lines are zero.
- R2: A 1 on bit k of `evt_set_i` at a clock edge sets event bit k. The bit stays set through idle cycles until it is cleared.
- R3: A write to the event register (address 0x1) clears every event bit whose written data bit is 1 and leaves the other bits unchanged.
- R4: A write to the mask register (address 0x2) replaces its whole value. A read of address 0x2 returns it, and a read of address 0x1 returns the event register.
- R5: Interrupt line k is high when event bit S(k) and mask bit S(k) are both set. S(0..12) = 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30. These bits are: tx frame 27, tx buffer 26, underrun 19, retry limit 20, rx frame 25, rx buffer 24, management done 23, late collision 21, heartbeat 31, graceful stop 28, bus error 22, babbling tx 29, babbling rx 30.
- R6: When a set pulse or an internal set and a clear write hit the same event bit in one cycle, the bit ends up set.
- R7: Any write to the management frame register (address 0x8) sets event bit 23.
- R8: A write to the transmit control register (address 0xC) with data bit 0 set sets event bit 28. With data bit 0 clear, the write changes nothing.
- R9: An interrupt line takes its new level in the same cycle as the register update that changes its active state, with no added register stage.
- R10: Event bits 0 to 18 are stored and readable but drive no interrupt line, whatever the mask.
- R11: A read of any address other than 0x1 and 0x2 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Combinational read data |
| evt_set_i | input | 32 | Per-bit event set pulses |
| irq_o | output | 13 | Interrupt request lines |

## Verification
The bench targets four corner cases:
- **Set and clear on the same bit in one cycle.** A design where the clear wins would lose an event that arrived during acknowledgement.
- **The out-of-order line mapping.** It is checked through lines 0, 2, 6, 8 and 9. A design with a straight bit-to-line slice would light the wrong lines.
- **Transmit control writes with bit 0 clear.** These must leave the event register untouched. A design that sets the graceful-stop event on any such write would raise it.
- **Events in the unmapped low bits with a full mask.** These must keep every line low. A design that leaks them through would show spurious interrupts.

The bench also checks that a mid-run reset drops a live interrupt. It also checks that lines respond in the same cycle as the register update and not one cycle later.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int NUM_IRQ = 13;

  localparam logic [ADDR_W-1:0] A_EVT   = 4'h1;
  localparam logic [ADDR_W-1:0] A_MSK   = 4'h2;
  localparam logic [ADDR_W-1:0] A_MGMT  = 4'h8;
  localparam logic [ADDR_W-1:0] A_TXCTL = 4'hC;

  localparam int B_HBEAT = 31;
  localparam int B_BABRX = 30;
  localparam int B_BABTX = 29;
  localparam int B_GSTOP = 28;
  localparam int B_TXFRM = 27;
  localparam int B_TXBUF = 26;
  localparam int B_RXFRM = 25;
  localparam int B_RXBUF = 24;
  localparam int B_MGMT  = 23;
  localparam int B_BUSER = 22;
  localparam int B_LCOL  = 21;
  localparam int B_RLIM  = 20;
  localparam int B_UNDR  = 19;
  localparam int B_LOW   = B_UNDR;  // lowest mapped bit

  // source event bit of each irq line, line 0 first
  localparam int IRQ_SRC [NUM_IRQ] = '{
    B_TXFRM, B_TXBUF, B_UNDR, B_RLIM, B_RXFRM, B_RXBUF, B_MGMT,
    B_LCOL, B_HBEAT, B_GSTOP, B_BUSER, B_BABTX, B_BABRX
  };
endpackage

// File: rtl/evirq_regs.sv
module evirq_regs
  import evirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] evt_set_i,
  output logic [DATA_W-1:0] evt_o,
  output logic [DATA_W-1:0] msk_o
);
  logic              hit_evt, hit_msk, hit_mgmt, hit_tx;
  logic [DATA_W-1:0] evt_q, msk_q, evt_d, clr, int_set;

  assign hit_evt  = wr_en_i && (wr_addr_i == A_EVT);
  assign hit_msk  = wr_en_i && (wr_addr_i == A_MSK);
  assign hit_mgmt = wr_en_i && (wr_addr_i == A_MGMT);
  assign hit_tx   = wr_en_i && (wr_addr_i == A_TXCTL);

  always_comb begin
    int_set          = '0;
    int_set[B_MGMT]  = hit_mgmt;
    int_set[B_GSTOP] = hit_tx & wr_data_i[0];
    clr              = hit_evt ? wr_data_i : '0;
    // sets applied after clear: set wins
    evt_d            = (evt_q & ~clr) | evt_set_i | int_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      msk_q <= '0;
    end else begin
      evt_q <= evt_d;
      if (hit_msk) msk_q <= wr_data_i;
    end
  end

  assign evt_o = evt_q;
  assign msk_o = msk_q;

  // R3
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_evt && evt_set_i == '0) |=> evt_q == ($past(evt_q) & ~$past(wr_data_i)));
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & $past(evt_set_i)) == $past(evt_set_i)));
  // R4
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_msk |=> msk_q == $past(wr_data_i));
  // R7
  mgmt_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_mgmt |=> evt_q[B_MGMT]);
  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && evt_set_i == '0) |=> $stable(evt_q));
endmodule

// File: rtl/evirq_fanout.sv
module evirq_fanout
  import evirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  evt_i,
  input  logic [DATA_W-1:0]  msk_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    assign irq_o[k] = evt_i[IRQ_SRC[k]] & msk_i[IRQ_SRC[k]];
  end

  // R5
  masked_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_i[DATA_W-1:B_LOW] == '0) |-> (irq_o == '0));
  // R10
  low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(evt_i[DATA_W-1:B_LOW]) && $stable(msk_i[DATA_W-1:B_LOW]) |-> $stable(irq_o));
  // R5
  line_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) == $countones(evt_i[DATA_W-1:B_LOW] & msk_i[DATA_W-1:B_LOW]));
endmodule

// File: rtl/evirq_unit.sv
module evirq_unit
  import evirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [DATA_W-1:0]  evt_set_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [DATA_W-1:0] evt, msk;

  evirq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .evt_set_i (evt_set_i),
    .evt_o     (evt),
    .msk_o     (msk)
  );

  evirq_fanout u_fanout (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .msk_i  (msk),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (rd_addr_i)
      A_EVT:   rd_data_o = evt;
      A_MSK:   rd_data_o = msk;
      default: rd_data_o = '0;
    endcase
  end

  // R8
  gstop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_TXCTL && wr_data_i[0]) |=> evt[B_GSTOP]);
  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (evt == '0 && msk == '0 && irq_o == '0));
endmodule

// File: tb/evirq_unit_tb.sv
module evirq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = 4'h1;
  logic [31:0] rd_data;
  logic [31:0] evt_set = '0;
  logic [12:0] irq;
  int checks = 0, fails = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  evirq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_set_i(evt_set), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] set;
    logic [31:0] exp_evt;
    logic [12:0] exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h0, 32'h0,         32'h0800_0020, 32'h0800_0020, 13'h0000, 4'd2},  // R2
    '{1'b1, 4'h2, 32'hFFFF_FFFF, 32'h0,         32'h0800_0020, 13'h0001, 4'd5},  // R5
    '{1'b0, 4'h0, 32'h0,         32'h8008_0000, 32'h8808_0020, 13'h0105, 4'd5},  // R5
    '{1'b1, 4'h1, 32'h0800_0000, 32'h0,         32'h8008_0020, 13'h0104, 4'd3},  // R3
    '{1'b1, 4'h2, 32'h8000_0000, 32'h0,         32'h8008_0020, 13'h0100, 4'd4},  // R4
    '{1'b1, 4'h1, 32'h8008_0000, 32'h8000_0000, 32'h8000_0020, 13'h0100, 4'd6},  // R6
    '{1'b1, 4'h8, 32'h0000_1234, 32'h0,         32'h8080_0020, 13'h0100, 4'd7},  // R7
    '{1'b1, 4'h2, 32'h00FF_FFFF, 32'h0,         32'h8080_0020, 13'h0040, 4'd5},  // R5
    '{1'b1, 4'hC, 32'h0000_0002, 32'h0,         32'h8080_0020, 13'h0040, 4'd8},  // R8
    '{1'b1, 4'hC, 32'h0000_0001, 32'h0,         32'h9080_0020, 13'h0040, 4'd8},  // R8
    '{1'b1, 4'h2, 32'hFFF8_0000, 32'h0,         32'h9080_0020, 13'h0340, 4'd5},  // R5
    '{1'b1, 4'h1, 32'hFFFF_FFFF, 32'h0,         32'h0000_0000, 13'h0000, 4'd3}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; evt_set = s;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; evt_set = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_addr = 4'h1; #1 check("R1 evt", rd_data, 32'h0);
    rd_addr = 4'h2; #1 check("R1 msk", rd_data, 32'h0);
    check("R1 irq", {19'h0, irq}, 32'h0);
    rst_n = 1'b1;
    rd_addr = 4'h1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].set);
      #1 check($sformatf("R%0d vec%0d evt", VECS[i].req, i), rd_data, VECS[i].exp_evt);
      check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {19'h0, irq}, {19'h0, VECS[i].exp_irq});
    end

    // R4 mask readback
    rd_addr = 4'h2; #1 check("R4 msk read", rd_data, 32'hFFF8_0000);
    // R11 other addresses read zero
    rd_addr = 4'h8; #1 check("R11 rd 0x8", rd_data, 32'h0);
    rd_addr = 4'h3; #1 check("R11 rd 0x3", rd_data, 32'h0);
    rd_addr = 4'h1;

    // R10 unmapped bits with full mask
    step(1'b1, 4'h2, 32'hFFFF_FFFF, 32'h0007_FFFF);
    #1 check("R10 evt low", rd_data, 32'h0007_FFFF);
    check("R10 irq", {19'h0, irq}, 32'h0);

    // R2 sticky over idle cycles
    repeat (5) @(negedge clk);
    #1 check("R2 sticky", rd_data, 32'h0007_FFFF);

    // R9 same-cycle irq response: babbling rx bit 30 -> line 12
    @(negedge clk); evt_set = 32'h4000_0000;
    @(posedge clk); #1 check("R9 irq same cycle", {19'h0, irq}, 32'h0000_1000);
    @(negedge clk); evt_set = '0;

    // R1 mid-run reset
    rst_n = 1'b0; #1;
    check("R1 rst irq", {19'h0, irq}, 32'h0);
    check("R1 rst evt", rd_data, 32'h0);
    rd_addr = 4'h2; #1 check("R1 rst msk", rd_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule